// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a general-purpose I/O port of 32 pins sitting behind a plain 32-bit register bus. Software sets, per pin, whether the pin drives out or samples in, and what value it drives. Every input is resynchronised to the port clock. A status bit for each pin latches interrupt events of a chosen kind: low level, high level, rising edge or falling edge. Software clears a status bit by writing one to it. A mask register selects which status bits reach the single, registered interrupt line.

The bus is write-strobe plus byte address. Reads are combinational from the address. The data register reads back the pin values: for output pins the value being driven, and for input pins the synchronised input. An edge event stays latched until software clears it. A level event that is cleared while the pin still sits at its active level latches again at once.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads zero and `pinOut`, `pinOe` and `irqOut` are all zero. Addresses that map no register read zero.
- R2: The direction word sits at byte address 0x04, and bit n = 1 makes pin n an output: `pinOe` equals the direction word and `pinOut` equals the data word at 0x00, one cycle after the write. Reading 0x00 returns the data word on output pins and the synchronised input on input pins.
- R3: The trigger type is a 2-bit field per pin. Pins 0–15 sit in the word at 0x08 and pins 16–31 in the word at 0x0C. The field of pin n starts at bit 2·(n mod 16). The encoding is 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R4: A pin input passes through two synchroniser flops. For a level trigger, the status bit is set on the third clock edge after the input reaches the active level, and it is not set while the input is inactive. The reset configuration (all zero) is low level.
- R5: An edge trigger compares the synchronised value with its value one cycle earlier. Once the status bit is set by the chosen transition, it stays set until software clears it, even after the input changes back.
- R6: A write to the status word at 0x14 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: A level-type status bit that is cleared while its synchronised input is still active reads as set again straight after the clear.
- R8: When a trigger event and a clearing write hit the same bit on the same clock edge, the bit ends up set.
- R9: `irqOut` is a registered OR over all pins of status AND mask (mask word at 0x10, bit n = 1 enables pin n). Reading 0x14 returns the raw status whatever the mask is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| pinIn | input | 32 | Raw pin inputs, asynchronous |
| pinOut | output | 32 | Output value of each pin |
| pinOe | output | 32 | Output enable of each pin |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The trigger logic is tried with single isolated transitions on chosen pins: a rise on a rising-edge pin, a fall on a falling-edge pin, and held and released levels on level pins. These show whether an edge latches and stays latched, and whether a level latches again after a clear. A rise placed so that its status update lands on the same edge as a clearing write separates set-priority from clear-priority. A long stretch of pseudo-random pin activity mixed with random writes to every register is compared against the reference model on every clock. It exposes wrong field offsets in the upper configuration word, wrong latency and wrong read-back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CFGLO = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CFGHI = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_t;

  typedef enum logic [2:0] {
    SEL_DATA, SEL_DIR, SEL_CFGLO, SEL_CFGHI, SEL_MASK, SEL_STAT, SEL_NONE
  } rdSel_t;

  typedef struct packed {
    logic data;
    logic dir;
    logic cfgLo;
    logic cfgHi;
    logic mask;
    logic clr;
  } wrStrobes_t;
endpackage

// File: rtl/gpio_regdec.sv
module gpio_regdec
  import gpio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobes_t        stb,
  output rdSel_t            rdSel
);
  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    unique case (addr)
      OFS_DATA:  begin rdSel = SEL_DATA;  stb.data  = wrEn; end
      OFS_DIR:   begin rdSel = SEL_DIR;   stb.dir   = wrEn; end
      OFS_CFGLO: begin rdSel = SEL_CFGLO; stb.cfgLo = wrEn; end
      OFS_CFGHI: begin rdSel = SEL_CFGHI; stb.cfgHi = wrEn; end
      OFS_MASK:  begin rdSel = SEL_MASK;  stb.mask  = wrEn; end
      OFS_STAT:  begin rdSel = SEL_STAT;  stb.clr   = wrEn; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobes_t       stb,
  input  rdSel_t           rdSel,
  input  logic [NPINS-1:0] wrData,
  output logic [NPINS-1:0] rdData,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut,
  output logic [NPINS-1:0] statusQ,
  output logic [NPINS-1:0] maskQ
);
  localparam int HALF  = NPINS / 2;
  localparam int CFG_W = 2 * NPINS;

  logic [NPINS-1:0] dataQ, dirQ, syncA, syncB, prevQ, hit;
  logic [CFG_W-1:0] cfgQ;

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      maskQ <= '0;
      cfgQ  <= '0;
    end else begin
      if (stb.data)  dataQ <= wrData;
      if (stb.dir)   dirQ  <= wrData;
      if (stb.mask)  maskQ <= wrData;
      if (stb.cfgLo) cfgQ[NPINS-1:0]     <= wrData;
      if (stb.cfgHi) cfgQ[CFG_W-1:NPINS] <= wrData;
    end
  end

  // per-pin trigger evaluation; field of pin p sits at 2*p across both words
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    trig_t trig;
    assign trig   = trig_t'(cfgQ[2*p +: 2]);
    assign hit[p] = (trig == TRIG_LOW)  ? ~syncB[p] :
                    (trig == TRIG_HIGH) ?  syncB[p] :
                    (trig == TRIG_RISE) ? (syncB[p] & ~prevQ[p]) :
                                          (~syncB[p] & prevQ[p]);
  end

  // status: new hits win over a clearing write on the same edge
  logic [NPINS-1:0] clrMask;
  assign clrMask = stb.clr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= hit | (statusQ & ~clrMask);
      irqOut  <= |(statusQ & maskQ);
    end
  end

  assign pinOut = dataQ;
  assign pinOe  = dirQ;

  always_comb begin
    unique case (rdSel)
      SEL_DATA:  rdData = (dirQ & dataQ) | (~dirQ & syncB);
      SEL_DIR:   rdData = dirQ;
      SEL_CFGLO: rdData = cfgQ[HALF*2-1:0];
      SEL_CFGHI: rdData = cfgQ[CFG_W-1:HALF*2];
      SEL_MASK:  rdData = maskQ;
      SEL_STAT:  rdData = statusQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wrData,
  output logic [NPINS-1:0]  rdData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irqOut
);
  wrStrobes_t       stb;
  rdSel_t           rdSel;
  logic [NPINS-1:0] statusBits, maskBits;

  gpio_regdec u_dec (
    .wrEn  (wrEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  gpio_datapath #(.NPINS(NPINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .rdData  (rdData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut),
    .statusQ (statusBits),
    .maskQ   (maskBits)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wrData,
  input logic [NPINS-1:0]  pinOut,
  input logic [NPINS-1:0]  pinOe,
  input logic              irqOut,
  input logic [NPINS-1:0]  statusQ,
  input logic [NPINS-1:0]  maskQ
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (irqOut == 1'b0 && pinOe == '0 && pinOut == '0));

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DIR) |=> pinOe == $past(wrData));

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == OFS_STAT) |=> (($past(statusQ) & ~statusQ) == '0));

  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_STAT) |=> (($past(statusQ) & ~$past(wrData) & ~statusQ) == '0));

  a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == (|($past(statusQ) & $past(maskQ))));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqOut  (irqOut),
  .statusQ (statusBits),
  .maskQ   (maskBits)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irqOut;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mData, mDir, mMask, mStat, mS1, mS2, mPrv;
  logic [1:0]  mCfg [32];
  logic        mIrq;

  always @(posedge clk) begin
    if (!rstN) begin
      mData <= 0; mDir <= 0; mMask <= 0; mStat <= 0;
      mS1 <= 0; mS2 <= 0; mPrv <= 0; mIrq <= 0;
      for (int p = 0; p < 32; p++) mCfg[p] <= 2'b00;
    end else begin
      logic [31:0] ev, clr;
      ev = 0;
      for (int p = 0; p < 32; p++) begin
        case (mCfg[p])
          2'b00: ev[p] = !mS2[p];
          2'b01: ev[p] = mS2[p];
          2'b10: ev[p] = mS2[p] && !mPrv[p];
          default: ev[p] = !mS2[p] && mPrv[p];
        endcase
      end
      clr = (wrEn && addr == 5'h14) ? wrData : 0;
      mStat <= ev | (mStat & ~clr);
      mIrq  <= (mStat & mMask) != 0;
      mS1 <= pinIn; mS2 <= mS1; mPrv <= mS2;
      if (wrEn) begin
        case (addr)
          5'h00: mData <= wrData;
          5'h04: mDir  <= wrData;
          5'h10: mMask <= wrData;
          5'h08: for (int p = 0; p < 16; p++) mCfg[p]    <= wrData[2*p +: 2];
          5'h0C: for (int p = 0; p < 16; p++) mCfg[p+16] <= wrData[2*p +: 2];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [4:0] a);
    logic [31:0] v;
    v = 0;
    case (a)
      5'h00: v = (mDir & mData) | (~mDir & mS2);
      5'h04: v = mDir;
      5'h08: for (int p = 0; p < 16; p++) v[2*p +: 2] = mCfg[p];
      5'h0C: for (int p = 0; p < 16; p++) v[2*p +: 2] = mCfg[p+16];
      5'h10: v = mMask;
      5'h14: v = mStat;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R2 pinOut", pinOut, mData);
      chk("R2 pinOe", pinOe, mDir);
      chk("R9 irqOut", {31'b0, irqOut}, {31'b0, mIrq});
      chk("R3/R6 rdData", rdData, modelRead(addr));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(logic [4:0] a, logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic readReg(logic [4:0] a, output logic [31:0] d);
    wrEn = 0; addr = a;
    #2;
    d = rdData;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  logic [31:0] rv;
  logic [31:0] lfsr;

  initial begin
    tick(3);
    // R1: reset state of every register and output
    for (int a = 0; a < 32; a += 4) begin
      readReg(a[4:0], rv);
      chk("R1 reset read", rv, 0);
    end
    chk("R1 reset pinOut", pinOut, 0);
    chk("R1 reset pinOe", pinOe, 0);
    chk("R1 reset irqOut", {31'b0, irqOut}, 0);
    tick();
    rstN = 1;
    tick(4);
    // R4: default low-level config with all inputs low latches every pin
    readReg(5'h14, rv);
    chk("R4 default low level", rv, 32'hFFFF_FFFF);

    pinIn = 32'hFFFF_FFFF;
    tick(4);
    doWrite(5'h08, 32'h0000_001E);   // pin0 rise, pin1 fall, pin2 high, pin3 low
    doWrite(5'h0C, 32'h0000_0002);   // pin16 rise
    readReg(5'h0C, rv);
    chk("R3 upper config word", rv, 32'h0000_0002);
    doWrite(5'h14, 32'hFFFF_FFFF);
    readReg(5'h14, rv);
    chk("R6/R7 clear all, high level pin2 remains", rv, 32'h0000_0004);

    // R2 direction and data
    doWrite(5'h04, 32'hFFFF_0000);
    doWrite(5'h00, 32'hA5A5_1234);
    chk("R2 pinOe", pinOe, 32'hFFFF_0000);
    chk("R2 pinOut", pinOut, 32'hA5A5_1234);
    readReg(5'h00, rv);
    chk("R2 data readback mix", rv, 32'hA5A5_FFFF);
    doWrite(5'h04, 32'h0);

    // R5 rising edge latches and stays
    pinIn[0] = 0; tick(4);
    pinIn[0] = 1; tick(4);
    readReg(5'h14, rv);
    chk("R5 rising edge latched", rv, 32'h0000_0005);
    pinIn[0] = 0; tick(4);
    readReg(5'h14, rv);
    chk("R5 edge stays latched", rv, 32'h0000_0005);

    // R6 write-one-to-clear
    doWrite(5'h14, 32'h0000_0001);
    readReg(5'h14, rv);
    chk("R6 w1c bit0 only", rv, 32'h0000_0004);
    // R7 level still active re-sets
    doWrite(5'h14, 32'h0000_0004);
    readReg(5'h14, rv);
    chk("R7 level re-set after clear", rv, 32'h0000_0004);
    pinIn[2] = 0; tick(4);
    doWrite(5'h14, 32'h0000_0004);
    tick(3);
    readReg(5'h14, rv);
    chk("R4 inactive level stays clear", rv, 32'h0);

    // R8 set wins over same-edge clear (status update on third edge)
    pinIn[16] = 0; tick(4);
    pinIn[16] = 1;
    tick(2);
    doWrite(5'h14, 32'h0001_0000);
    readReg(5'h14, rv);
    chk("R8 set wins", rv, 32'h0001_0000);
    doWrite(5'h14, 32'h0001_0000);
    readReg(5'h14, rv);
    chk("R6 later clear works", rv, 32'h0);

    // R5 falling and R4 low level
    pinIn[1] = 0; pinIn[3] = 0; tick(4);
    readReg(5'h14, rv);
    chk("R5/R4 falling and low", rv, 32'h0000_000A);

    // R9 masking
    chk("R9 masked off", {31'b0, irqOut}, 0);
    doWrite(5'h10, 32'h0000_0002);
    tick();
    chk("R9 irq raised", {31'b0, irqOut}, 1);
    doWrite(5'h14, 32'h0000_0002);
    tick();
    chk("R9 irq dropped", {31'b0, irqOut}, 0);
    readReg(5'h14, rv);
    chk("R9 raw status unmasked bit", rv, 32'h0000_0008);
    readReg(5'h18, rv);
    chk("R1 unmapped reads zero", rv, 0);

    // random traffic compared with the model every clock
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pinIn = pinIn ^ (lfsr & 32'h0101_0101);
      if (lfsr[7:5] == 3'd0) begin
        wrEn = 1;
        addr = 5'(4 * (lfsr[12:10] % 6));
        wrData = {lfsr[15:0], lfsr[31:16]};
      end else begin
        wrEn = 0;
        addr = 5'(4 * (lfsr[14:12] % 7));
      end
      tick();
    end
    wrEn = 0;
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule